// File: doc/BRIEF.md
# Multi-Mode Timer/Counter

This block is a single timer/counter channel whose count lives in a pair of byte registers, a high byte and a low byte. A two-bit mode field decides how the pair behaves:
- a 13-bit counter,
- a full 16-bit counter,
- an 8-bit counter that reloads itself from the high byte.

A source select decides what advances the count:
- a qualified internal tick, or
- falling edges of an asynchronous external pin, which first passes through a synchronizer.

A run bit gates all counting.

When the count rolls over, an overflow flag is set. The flag can drive an interrupt request. Software clears the flag, or the interrupt acknowledge clears it. Software loads and reads either byte through a byte-wide write port and a read select.

Top module: `tmr_unit`

## Requirements
- R1: After reset (active-low `rstN`), both count bytes read 0x00, and `ovfFlag` and `irqOut` are 0.
- R2: With `cfgMode` = 2'b00 (13-bit), each count event increments the value {high byte, low byte bits 4:0}. Low byte bits 7:5 are unchanged. Going from 0x1FFF to 0x0000 is an overflow.
- R3: With `cfgMode` = 2'b01 (16-bit), each count event increments {high, low}. Going from 0xFFFF to 0x0000 is an overflow.
- R4: With `cfgMode` = 2'b10 (auto-reload), each count event increments the low byte only. An event at 0xFF loads the low byte from the high byte and is an overflow. The high byte never changes in this mode except by a software write.
- R5: With `cfgExtSel` = 1, a count event is a falling edge of `extIn`, seen after a two-flop synchronizer. Rising edges and `tickIn` have no effect. With `cfgExtSel` = 0, a count event is any cycle in which `tickIn` = 1.
- R6: An overflow sets `ovfFlag` on the next clock. `irqOut` equals `ovfFlag` AND `irqEn`.
- R7: `flagClr` = 1 or `intAck` = 1 clears `ovfFlag` on the next clock. An overflow in the same cycle wins, and the flag stays set.
- R8: While `cfgRun` = 0, no count event changes either byte or the flag.
- R9: A write (`wrEn` = 1, `wrSel` 0 = low byte, 1 = high byte) loads `wrData` on the next clock. Any increment in that same cycle is discarded.
- R10: With `cfgMode` = 2'b11, count events are ignored and both bytes hold.
- R11: `rdData` shows the low byte when `rdSel` = 0 and the high byte when `rdSel` = 1, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | Counting mode: 00 13-bit, 01 16-bit, 10 reload, 11 hold |
| cfgExtSel | input | 1 | 1 = count external falling edges, 0 = count tickIn |
| cfgRun | input | 1 | Enables counting |
| tickIn | input | 1 | Internal count qualifier |
| extIn | input | 1 | Asynchronous external count pin |
| wrEn | input | 1 | Byte write strobe |
| wrSel | input | 1 | Write target: 0 low, 1 high |
| wrData | input | 8 | Write data |
| rdSel | input | 1 | Read select: 0 low, 1 high |
| rdData | output | 8 | Selected byte |
| flagClr | input | 1 | Software flag clear |
| intAck | input | 1 | Interrupt acknowledge, clears flag |
| irqEn | input | 1 | Interrupt enable |
| ovfFlag | output | 1 | Overflow flag |
| irqOut | output | 1 | Interrupt request |

## Verification
The rollover paths are hard to reach from the ports. Counting up from zero would take thousands of events. The bench therefore writes start values a few steps below each mode's wrap point. It then runs long tick bursts that cross the wrap one or more times. An arithmetic step model in the bench predicts the bytes and the flag. Two other cases need exact cycle placement of the stimulus: a write in the same cycle as an increment, and an overflow in the same cycle as a flag clear. External counting is driven with slow pin toggles, so that rising and falling edges both pass through the synchronizer.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13  = 2'b00,
    MODE_16  = 2'b01,
    MODE_RLD = 2'b10,
    MODE_OFF = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic inc;
    logic wrLo;
    logic wrHi;
    logic clrFlag;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgExtSel,
  input  logic        cfgRun,
  input  logic        tickIn,
  input  logic        extIn,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic        flagClr,
  input  logic        intAck,
  output tmr_strobe_t stb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic extSync;
  logic extPrev;
  logic extFall;
  logic srcEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      extPrev <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extIn};
      extPrev <= extSync;
    end
  end

  assign extSync  = syncQ[SYNC_STAGES-1];
  assign extFall  = extPrev & ~extSync;
  assign srcEvent = cfgExtSel ? extFall : tickIn;

  always_comb begin
    stb.inc     = cfgRun & srcEvent;
    stb.wrLo    = wrEn & ~wrSel;
    stb.wrHi    = wrEn & wrSel;
    stb.clrFlag = flagClr | intAck;
  end

  AST_RUN_GATES_EVENTS: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRun |-> !stb.inc); // R8
  AST_EXT_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (cfgExtSel && stb.inc) |-> (!extSync && $past(extSync))); // R5
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LOW_PART_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  tmr_strobe_t       stb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] cntLo,
  output logic [BYTE_W-1:0] cntHi,
  output logic              ovfFlag
);
  localparam int PAIR_W = 2 * BYTE_W;

  tmr_mode_e modeSel;
  logic [BYTE_W-1:0] nextLo;
  logic [BYTE_W-1:0] nextHi;
  logic              ovfNow;
  logic [BYTE_W:0]   hiSum;
  logic [PAIR_W:0]   pairSum;

  assign modeSel = tmr_mode_e'(cfgMode);
  assign hiSum   = {1'b0, cntHi} + (BYTE_W+1)'(1);
  assign pairSum = {1'b0, cntHi, cntLo} + (PAIR_W+1)'(1);

  always_comb begin
    nextLo = cntLo;
    nextHi = cntHi;
    ovfNow = 1'b0;
    if (stb.wrLo || stb.wrHi) begin
      if (stb.wrLo) nextLo = wrData;
      if (stb.wrHi) nextHi = wrData;
    end else if (stb.inc) begin
      case (modeSel)
        MODE_13: begin
          if (&cntLo[LOW_PART_W-1:0]) begin
            nextLo[LOW_PART_W-1:0] = '0;
            nextHi = hiSum[BYTE_W-1:0];
            ovfNow = hiSum[BYTE_W];
          end else begin
            nextLo[LOW_PART_W-1:0] = cntLo[LOW_PART_W-1:0] + LOW_PART_W'(1);
          end
        end
        MODE_16: begin
          {nextHi, nextLo} = pairSum[PAIR_W-1:0];
          ovfNow = pairSum[PAIR_W];
        end
        MODE_RLD: begin
          if (&cntLo) begin
            nextLo = cntHi;
            ovfNow = 1'b1;
          end else begin
            nextLo = cntLo + BYTE_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo   <= '0;
      cntHi   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      cntLo <= nextLo;
      cntHi <= nextHi;
      if (ovfNow) ovfFlag <= 1'b1;
      else if (stb.clrFlag) ovfFlag <= 1'b0;
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrLo |=> (cntLo == $past(wrData))); // R9
  AST_RELOAD_HI_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_RLD && !stb.wrHi) |=> $stable(cntHi)); // R4
  AST_M13_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_13 && !stb.wrLo) |=> $stable(cntLo[BYTE_W-1:LOW_PART_W])); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.inc && !stb.wrLo && !stb.wrHi) |=> ($stable(cntLo) && $stable(cntHi))); // R8
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_OFF && !stb.wrLo && !stb.wrHi) |=> ($stable(cntLo) && $stable(cntHi))); // R10
  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ovfNow |=> ovfFlag); // R6
  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrFlag && !ovfNow) |=> !ovfFlag); // R7
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LOW_PART_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic              cfgExtSel,
  input  logic              cfgRun,
  input  logic              tickIn,
  input  logic              extIn,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdSel,
  output logic [BYTE_W-1:0] rdData,
  input  logic              flagClr,
  input  logic              intAck,
  input  logic              irqEn,
  output logic              ovfFlag,
  output logic              irqOut
);
  tmr_strobe_t stb;
  logic [BYTE_W-1:0] cntLo;
  logic [BYTE_W-1:0] cntHi;

  tmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgExtSel(cfgExtSel), .cfgRun(cfgRun),
    .tickIn(tickIn), .extIn(extIn), .wrEn(wrEn), .wrSel(wrSel),
    .flagClr(flagClr), .intAck(intAck), .stb(stb)
  );

  tmr_datapath #(.BYTE_W(BYTE_W), .LOW_PART_W(LOW_PART_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .stb(stb), .wrData(wrData),
    .cntLo(cntLo), .cntHi(cntHi), .ovfFlag(ovfFlag)
  );

  assign rdData = rdSel ? cntHi : cntLo;
  assign irqOut = ovfFlag & irqEn;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (ovfFlag && irqEn)); // R6
endmodule

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cfgMode = 2'b01;
  logic cfgExtSel = 1'b0, cfgRun = 1'b0, tickIn = 1'b0, extIn = 1'b1;
  logic wrEn = 1'b0, wrSel = 1'b0, rdSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic flagClr = 1'b0, intAck = 1'b0, irqEn = 1'b0;
  logic ovfFlag, irqOut;
  int nTests = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tmr_unit u0 (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgExtSel(cfgExtSel),
    .cfgRun(cfgRun), .tickIn(tickIn), .extIn(extIn), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .flagClr(flagClr), .intAck(intAck), .irqEn(irqEn),
    .ovfFlag(ovfFlag), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdPair(output logic [7:0] h, output logic [7:0] l);
    @(negedge clk);
    rdSel = 1'b0; #0.5 l = rdData;
    rdSel = 1'b1; #0.5 h = rdData;
    rdSel = 1'b0;
  endtask

  task automatic pulseClr;
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  task automatic runTicks(input int n);
    @(negedge clk);
    cfgRun = 1'b1; tickIn = 1'b1;
    repeat (n) @(negedge clk);
    cfgRun = 1'b0; tickIn = 1'b0;
  endtask

  // returns {ovf, hi, lo} after one count event
  function automatic logic [16:0] stepModel(input int m, input logic [7:0] h, input logic [7:0] l);
    logic [16:0] r;
    case (m)
      0: if (l[4:0] == 5'h1F) r = {h == 8'hFF, h + 8'd1, l[7:5], 5'd0};
         else r = {1'b0, h, l + 8'd1};
      1: if ({h, l} == 16'hFFFF) r = 17'h10000;
         else r = {1'b0, {h, l} + 16'd1};
      2: if (l == 8'hFF) r = {1'b1, h, h};
         else r = {1'b0, h, l + 8'd1};
      default: r = {1'b0, h, l};
    endcase
    return r;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] h, l, eh, el;
    logic ef;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdPair(h, l);
    chk("R1 reset bytes", {h, l}, 16'h0000);
    chk("R1 reset flag", {15'd0, ovfFlag}, 16'd0);
    chk("R1 reset irq", {15'd0, irqOut}, 16'd0);

    // R2 R3 R4 sweep: modes x start points x burst lengths
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 4; s++) begin
        int n;
        logic [16:0] st;
        case (s)
          0: begin eh = 8'hFF; el = 8'hF0; end
          1: begin eh = 8'hFF; el = 8'hFC; end
          2: begin eh = 8'h80; el = 8'hFE; end
          default: begin eh = 8'h7F; el = 8'hFF; end
        endcase
        n = 17 + 61 * s;
        cfgMode = 2'(m);
        wrReg(1'b1, eh);
        wrReg(1'b0, el);
        pulseClr;
        ef = 1'b0;
        for (int k = 0; k < n; k++) begin
          st = stepModel(m, eh, el);
          ef = ef | st[16];
          eh = st[15:8]; el = st[7:0];
        end
        runTicks(n);
        rdPair(h, l);
        if (m == 0) chk("R2 13-bit count", {h, l}, {eh, el});
        else if (m == 1) chk("R3 16-bit count", {h, l}, {eh, el});
        else chk("R4 reload count", {h, l}, {eh, el});
        chk("R6 flag after burst", {15'd0, ovfFlag}, {15'd0, ef});
      end
    end

    // R6 irq gating (flag is set from last burst)
    irqEn = 1'b0; #0.5;
    chk("R6 irq masked", {15'd0, irqOut}, 16'd0);
    irqEn = 1'b1; #0.5;
    chk("R6 irq enabled", {15'd0, irqOut}, {15'd0, ovfFlag});

    // R7 clear by ack
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    chk("R7 ack clears", {15'd0, ovfFlag}, 16'd0);
    // R7 overflow beats clear
    cfgMode = 2'b10;
    wrReg(1'b1, 8'h00); wrReg(1'b0, 8'hFF);
    @(negedge clk); cfgRun = 1'b1; tickIn = 1'b1; flagClr = 1'b1;
    @(negedge clk); cfgRun = 1'b0; tickIn = 1'b0; flagClr = 1'b0;
    chk("R7 set wins over clear", {15'd0, ovfFlag}, 16'd1);
    pulseClr;
    chk("R7 software clear", {15'd0, ovfFlag}, 16'd0);

    // R8 run gate
    cfgMode = 2'b01;
    wrReg(1'b1, 8'h12); wrReg(1'b0, 8'h34);
    @(negedge clk); tickIn = 1'b1;
    repeat (10) @(negedge clk);
    tickIn = 1'b0;
    rdPair(h, l);
    chk("R8 stopped holds", {h, l}, 16'h1234);

    // R9 write beats increment
    @(negedge clk); cfgRun = 1'b1; tickIn = 1'b1; wrEn = 1'b1; wrSel = 1'b0; wrData = 8'h40;
    @(negedge clk); cfgRun = 1'b0; tickIn = 1'b0; wrEn = 1'b0;
    rdPair(h, l);
    chk("R9 write priority", {h, l}, 16'h1240);

    // R10 mode 11 holds
    cfgMode = 2'b11;
    runTicks(9);
    rdPair(h, l);
    chk("R10 hold mode", {h, l}, 16'h1240);

    // R5 external falling edges, tickIn ignored
    cfgMode = 2'b01; cfgExtSel = 1'b1;
    wrReg(1'b1, 8'h00); wrReg(1'b0, 8'h00);
    @(negedge clk); cfgRun = 1'b1; tickIn = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 7; k++) begin
      extIn = 1'b0; repeat (4) @(negedge clk);
      extIn = 1'b1; repeat (4) @(negedge clk);
    end
    cfgRun = 1'b0; tickIn = 1'b0;
    rdPair(h, l);
    chk("R5 external falls", {h, l}, 16'd7);
    cfgExtSel = 1'b0;

    // R11 read select
    wrReg(1'b1, 8'hA5); wrReg(1'b0, 8'h5A);
    @(negedge clk); rdSel = 1'b1; #0.5;
    chk("R11 read high", {8'h00, rdData}, 16'h00A5);
    rdSel = 1'b0; #0.5;
    chk("R11 read low", {8'h00, rdData}, 16'h005A);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule